// File: doc/BRIEF.md
# Quad Converter Register Front End

This block is the digital side of a four-channel, 12-bit voltage-output converter. A host reaches it through one parallel port. The port has a 12-bit data path, a channel address, a piece select and a width code, a chip select, and read and write strobes. Mode-select and update controls complete the port. Each channel has two ranks of storage. The staging rank is written from the port. The live rank feeds the converter. A separate update command copies staging to live for any set of channels at once, so several channels can be preloaded and then changed together.

A host can write a channel in three ways: as one 12-bit word, as a byte plus a nibble, or as three nibbles. Which one depends on how wide its own bus is. The staging rank and a per-channel mode register can be read back. The read path drives the bus only during a read, which models a tristate driver. Each channel has three mode bits:

- bipolar range;
- gain of two;
- transparent, which makes a write reach both ranks in the same cycle.

An asynchronous zero input forces every live output to its zero code at once. The zero code is mid-scale for bipolar channels and code 0 for unipolar channels. While zero is held, the stored values are kept, and the outputs return to them when zero is released.

Top module: `quad_dac_regif`

## Requirements
- R1: After rst_n is released, every channel's staging and live values are 0x000 and its mode is 0. All dac_code fields read 0x000, dac_bip and dac_gain2 are 0, and data_oe is 0.
- R2: A data write is cs=1, wr=1, mode_sel=0, upd=0. With bus_width=2 and part=0 it stores data_in[11:0] in the staging rank of the channel selected by addr, and of no other channel. A non-transparent channel's dac_code does not change on a write.
- R3: With bus_width=0, a data write puts data_in[3:0] into staging bits 3:0, 7:4 or 11:8 for part 0, 1 or 2, and leaves the other bits unchanged. With part 3 the write is ignored.
- R4: With bus_width=1, part 0 puts data_in[7:0] into staging bits 7:0, and part 1 puts data_in[3:0] into bits 11:8. The following writes are ignored:
  - parts 2 and 3 at bus_width=1;
  - any part other than 0 at bus_width=2;
  - any write at bus_width=3.
- R5: When cs=1 and upd=1, every channel whose bit is set in data_in[3:0] (bit n selects channel n) copies its staging value to its live value in that clock cycle. Channels whose bit is clear keep their live value.
- R6: A data read is cs=1, rd=1, wr=0, mode_sel=0. It drives data_oe=1. data_out carries the addressed channel's staging piece, selected by bus_width and part in the same way as for writes, right-justified with zeros above it. A piece that does not exist reads as zero.
- R7: When cs=0 or rd=0, data_oe=0 and data_out=0x000.
- R8: A mode write is cs=1, wr=1, mode_sel=1. It stores data_in[2:0] as the addressed channel's mode: bit 0 bipolar, bit 1 gain of two, bit 2 transparent. dac_bip and dac_gain2 follow bits 0 and 1. A read with mode_sel=1 returns the mode in data_out[2:0], with zeros above.
- R9: For a channel in transparent mode, a data write updates its live value in the same clock cycle as its staging value.
- R10: While zero_n=0, every dac_code field is 0x800 if that channel is bipolar and 0x000 otherwise, with no clock edge needed. Releasing zero_n brings back the stored live values unchanged.
- R11: A write or update strobe with cs=0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of all registers |
| zero_n | input | 1 | Asynchronous active-low force of outputs to zero code |
| cs | input | 1 | Chip select, active high |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| mode_sel | input | 1 | Selects the mode register instead of data |
| upd | input | 1 | Update strobe; data_in[3:0] is the channel mask |
| addr | input | 2 | Channel address |
| bus_width | input | 2 | 0 = 4-bit, 1 = 8-bit, 2 = 12-bit, 3 = reserved |
| part | input | 2 | Piece select within the 12-bit register |
| data_in | input | 12 | Write data and update mask |
| data_out | output | 12 | Readback data, zero when not driven |
| data_oe | output | 1 | High while the block drives the bus |
| dac_code | output | 48 | Live codes, channel n in bits 12n+11:12n |
| dac_bip | output | 4 | Bipolar range per channel |
| dac_gain2 | output | 4 | Gain-of-two per channel |

## Verification
Assertions check the following on every cycle:
- an update copies exactly the staging value into the live rank;
- the live rank holds unless an update or a transparent write occurs;
- a write never touches two channels;
- the bus is quiet outside reads;
- the zero override matches each channel's range.

Only the bench scenarios can show the following:
- that nibble and byte pieces land in the right bit positions;
- that ignored piece codes leave the register intact;
- that preloaded channels move together on a masked update;
- that the stored values come back after zero is released.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int DW = 12;
  localparam int MW = 3;

  typedef struct packed {
    logic transp;
    logic gain2;
    logic bip;
  } mode_t;

  // width code and piece select -> bits of the 12-bit register touched
  function automatic logic [DW-1:0] piece_mask(input logic [1:0] bw, input logic [1:0] pt);
    case ({bw, pt})
      4'b0000: return 12'h00F;
      4'b0001: return 12'h0F0;
      4'b0010: return 12'hF00;
      4'b0100: return 12'h0FF;
      4'b0101: return 12'hF00;
      4'b1000: return 12'hFFF;
      default: return 12'h000;
    endcase
  endfunction

  function automatic int unsigned piece_shift(input logic [1:0] bw, input logic [1:0] pt);
    case ({bw, pt})
      4'b0001: return 4;
      4'b0010: return 8;
      4'b0101: return 8;
      default: return 0;
    endcase
  endfunction

  function automatic logic piece_ok(input logic [1:0] bw, input logic [1:0] pt);
    return piece_mask(bw, pt) != '0;
  endfunction

  function automatic logic [DW-1:0] merge_piece(input logic [DW-1:0] old, input logic [DW-1:0] din,
                                                input logic [1:0] bw, input logic [1:0] pt);
    logic [DW-1:0] m;
    m = piece_mask(bw, pt);
    return (old & ~m) | ((din << piece_shift(bw, pt)) & m);
  endfunction

  function automatic logic [DW-1:0] extract_piece(input logic [DW-1:0] val,
                                                  input logic [1:0] bw, input logic [1:0] pt);
    return (val & piece_mask(bw, pt)) >> piece_shift(bw, pt);
  endfunction

  function automatic logic [DW-1:0] zero_code(input logic bip);
    return bip ? 12'h800 : 12'h000;
  endfunction
endpackage

// File: rtl/qdac_decode.sv
module qdac_decode
  import qdac_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int AW = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            wr,
  input  logic            rd,
  input  logic            mode_sel,
  input  logic            upd,
  input  logic [AW-1:0]   addr,
  input  logic [1:0]      bus_width,
  input  logic [1:0]      part,
  input  logic [N_CH-1:0] upd_mask,
  output logic [N_CH-1:0] data_we,
  output logic [N_CH-1:0] mode_we,
  output logic [N_CH-1:0] upd_en,
  output logic            rd_data_en,
  output logic            rd_mode_en
);
  logic wr_cycle;
  logic piece_good;

  assign wr_cycle   = cs && wr && !upd;
  assign piece_good = piece_ok(bus_width, part);

  for (genvar i = 0; i < N_CH; i++) begin : g_dec
    logic hit;
    assign hit        = (addr == AW'(i));
    assign data_we[i] = wr_cycle && !mode_sel && piece_good && hit;
    assign mode_we[i] = wr_cycle && mode_sel && hit;
    assign upd_en[i]  = cs && upd && upd_mask[i];
  end

  assign rd_data_en = cs && rd && !wr && !mode_sel;
  assign rd_mode_en = cs && rd && !wr && mode_sel;

  // R2
  single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_we | mode_we));
endmodule

// File: rtl/qdac_chan.sv
module qdac_chan
  import qdac_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          data_we,
  input  logic          mode_we,
  input  logic          upd_en,
  input  logic [DW-1:0] din,
  input  logic [1:0]    bus_width,
  input  logic [1:0]    part,
  output logic [DW-1:0] rank1,
  output logic [DW-1:0] rank2,
  output mode_t         mode_q
);
  logic [DW-1:0] rank1_nxt;
  logic          pass_through;

  assign rank1_nxt    = merge_piece(rank1, din, bus_width, part);
  assign pass_through = data_we && mode_q.transp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rank1  <= '0;
      rank2  <= '0;
      mode_q <= '0;
    end else begin
      if (data_we) rank1 <= rank1_nxt;
      if (mode_we) mode_q <= mode_t'(din[MW-1:0]);
      if (upd_en) rank2 <= rank1;
      else if (pass_through) rank2 <= rank1_nxt;
    end
  end

  // R5
  update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> rank2 == $past(rank1));

  // R2
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !pass_through) |=> $stable(rank2));

  // R9
  transp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_through && !upd_en) |=> rank2 == rank1);
endmodule

// File: rtl/qdac_readmux.sv
module qdac_readmux
  import qdac_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int AW = $clog2(N_CH)
) (
  input  logic [N_CH*DW-1:0] rank1_flat,
  input  logic [N_CH*MW-1:0] mode_flat,
  input  logic [AW-1:0]      addr,
  input  logic [1:0]         bus_width,
  input  logic [1:0]         part,
  input  logic               rd_data_en,
  input  logic               rd_mode_en,
  output logic [DW-1:0]      dout,
  output logic               oe
);
  logic [DW-1:0] sel_data;
  logic [MW-1:0] sel_mode;

  always_comb begin
    sel_data = rank1_flat[addr*DW +: DW];
    sel_mode = mode_flat[addr*MW +: MW];
    dout     = '0;
    if (rd_data_en)      dout = extract_piece(sel_data, bus_width, part);
    else if (rd_mode_en) dout = {{(DW-MW){1'b0}}, sel_mode};
  end

  assign oe = rd_data_en || rd_mode_en;
endmodule

// File: rtl/quad_dac_regif.sv
module quad_dac_regif
  import qdac_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int AW = $clog2(N_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               zero_n,
  input  logic               cs,
  input  logic               wr,
  input  logic               rd,
  input  logic               mode_sel,
  input  logic               upd,
  input  logic [AW-1:0]      addr,
  input  logic [1:0]         bus_width,
  input  logic [1:0]         part,
  input  logic [DW-1:0]      data_in,
  output logic [DW-1:0]      data_out,
  output logic               data_oe,
  output logic [N_CH*DW-1:0] dac_code,
  output logic [N_CH-1:0]    dac_bip,
  output logic [N_CH-1:0]    dac_gain2
);
  logic [N_CH-1:0]    data_we, mode_we, upd_en;
  logic               rd_data_en, rd_mode_en;
  logic [N_CH*DW-1:0] rank1_flat;
  logic [N_CH*MW-1:0] mode_flat;

  qdac_decode #(.N_CH(N_CH)) u_dec (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .rd(rd),
    .mode_sel(mode_sel), .upd(upd), .addr(addr),
    .bus_width(bus_width), .part(part), .upd_mask(data_in[N_CH-1:0]),
    .data_we(data_we), .mode_we(mode_we), .upd_en(upd_en),
    .rd_data_en(rd_data_en), .rd_mode_en(rd_mode_en)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic [DW-1:0] r1, r2;
    mode_t         md;

    qdac_chan u_chan (
      .clk(clk), .rst_n(rst_n), .data_we(data_we[i]), .mode_we(mode_we[i]),
      .upd_en(upd_en[i]), .din(data_in), .bus_width(bus_width), .part(part),
      .rank1(r1), .rank2(r2), .mode_q(md)
    );

    assign rank1_flat[i*DW +: DW] = r1;
    assign mode_flat[i*MW +: MW]  = md;
    assign dac_code[i*DW +: DW]   = zero_n ? r2 : zero_code(md.bip);
    assign dac_bip[i]             = md.bip;
    assign dac_gain2[i]           = md.gain2;

    // R10
    zero_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !zero_n |-> dac_code[i*DW +: DW] == (dac_bip[i] ? 12'h800 : 12'h000));
  end

  qdac_readmux #(.N_CH(N_CH)) u_rd (
    .rank1_flat(rank1_flat), .mode_flat(mode_flat), .addr(addr),
    .bus_width(bus_width), .part(part), .rd_data_en(rd_data_en),
    .rd_mode_en(rd_mode_en), .dout(data_out), .oe(data_oe)
  );

  // R7
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == '0);

  // R6
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd && !wr) |-> data_oe);
endmodule

// File: tb/tb_quad_dac_regif.sv
`timescale 1ns/1ps
module tb_quad_dac_regif;
  localparam int NC = 4;

  logic clk = 0, rst_n = 0, zero_n = 1, cs = 0, wr = 0, rd = 0, mode_sel = 0, upd = 0;
  logic [1:0] addr = 0, bus_width = 0, part = 0;
  logic [11:0] data_in = 0;
  logic [11:0] data_out;
  logic data_oe;
  logic [NC*12-1:0] dac_code;
  logic [NC-1:0] dac_bip, dac_gain2;

  quad_dac_regif dut (
    .clk(clk), .rst_n(rst_n), .zero_n(zero_n), .cs(cs), .wr(wr), .rd(rd),
    .mode_sel(mode_sel), .upd(upd), .addr(addr), .bus_width(bus_width),
    .part(part), .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .dac_code(dac_code), .dac_bip(dac_bip), .dac_gain2(dac_gain2)
  );

  always #2.5 clk = ~clk;

  // reference model
  int m_r1[NC], m_r2[NC], m_md[NC];
  bit m_zero = 0;
  int n_chk = 0, n_bad = 0;

  // scoreboard queues
  string q_tag[$];
  int q_kind[$], q_idx[$], q_exp[$];

  function automatic int piece_bits(int bw, int pt);
    if (bw == 0 && pt < 3) return 4;
    if (bw == 1 && pt == 0) return 8;
    if (bw == 1 && pt == 1) return 4;
    if (bw == 2 && pt == 0) return 12;
    return 0;
  endfunction

  function automatic int piece_lo(int bw, int pt);
    if (bw == 0) return 4 * pt;
    if (bw == 1 && pt == 1) return 8;
    return 0;
  endfunction

  function automatic int live_exp(int ch);
    if (m_zero) return (m_md[ch] & 1) ? 'h800 : 0;
    return m_r2[ch];
  endfunction

  function automatic int actual(int kind, int idx);
    case (kind)
      0: return int'(dac_code[idx*12 +: 12]);
      1: return int'(data_out);
      2: return int'(data_oe);
      3: return int'(dac_bip[idx]);
      default: return int'(dac_gain2[idx]);
    endcase
  endfunction

  task automatic push(string tag, int kind, int idx, int exp);
    q_tag.push_back(tag); q_kind.push_back(kind); q_idx.push_back(idx); q_exp.push_back(exp);
  endtask

  // monitor: pops expected items and compares with the outputs
  task automatic drain();
    while (q_tag.size() > 0) begin
      string t = q_tag.pop_front();
      int k = q_kind.pop_front();
      int i = q_idx.pop_front();
      int e = q_exp.pop_front();
      int a = actual(k, i);
      n_chk++;
      if (a != e) begin
        n_bad++;
        $display("FAIL %s (kind %0d idx %0d): actual %h expected %h", t, k, i, a, e);
      end
    end
  endtask

  task automatic expect_codes(string tag);
    for (int c = 0; c < NC; c++) push(tag, 0, c, live_exp(c));
    drain();
  endtask

  task automatic idle();
    cs = 0; wr = 0; rd = 0; mode_sel = 0; upd = 0; data_in = 0;
  endtask

  task automatic bus_write(int ch, int bw, int pt, int v, bit sel);
    @(negedge clk);
    cs = sel; wr = 1; addr = 2'(ch); bus_width = 2'(bw); part = 2'(pt); data_in = 12'(v);
    @(negedge clk);
    idle();
    if (sel && piece_bits(bw, pt) > 0) begin
      int n = piece_bits(bw, pt), lo = piece_lo(bw, pt);
      int mask = ((1 << n) - 1) << lo;
      m_r1[ch] = ((m_r1[ch] & ~mask) | ((v << lo) & mask)) & 'hFFF;
      if (m_md[ch] & 4) m_r2[ch] = m_r1[ch];
    end
    #1;
  endtask

  task automatic mode_write(int ch, int m);
    @(negedge clk);
    cs = 1; wr = 1; mode_sel = 1; addr = 2'(ch); data_in = 12'(m);
    @(negedge clk);
    idle();
    m_md[ch] = m & 7;
    #1;
  endtask

  task automatic update(int mask, bit sel);
    @(negedge clk);
    cs = sel; upd = 1; data_in = 12'(mask);
    @(negedge clk);
    idle();
    if (sel) for (int c = 0; c < NC; c++) if ((mask >> c) & 1) m_r2[c] = m_r1[c];
    #1;
  endtask

  task automatic bus_read(string tag, int ch, int bw, int pt, bit msel);
    int e;
    @(negedge clk);
    cs = 1; rd = 1; mode_sel = msel; addr = 2'(ch); bus_width = 2'(bw); part = 2'(pt);
    #1;
    if (msel) e = m_md[ch];
    else if (piece_bits(bw, pt) == 0) e = 0;
    else e = (m_r1[ch] >> piece_lo(bw, pt)) & ((1 << piece_bits(bw, pt)) - 1);
    push(tag, 1, 0, e);
    push(tag, 2, 0, 1);
    drain();
    idle();
  endtask

  task automatic set_zero(bit z);
    @(negedge clk);
    zero_n = !z; m_zero = z;
    #1;
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin m_r1[c] = 0; m_r2[c] = 0; m_md[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    expect_codes("R1 codes");
    push("R1 oe", 2, 0, 0);
    for (int c = 0; c < NC; c++) begin push("R1 bip", 3, c, 0); push("R1 gain", 4, c, 0); end
    drain();

    // R2 word write stays in staging
    bus_write(0, 2, 0, 'hABC, 1);
    expect_codes("R2 live unchanged");
    bus_read("R2 readback", 0, 2, 0, 0);
    bus_read("R2 other channel", 1, 2, 0, 0);

    // R5 preload and masked update
    bus_write(1, 2, 0, 'h123, 1);
    bus_write(2, 2, 0, 'h456, 1);
    update('b0101, 1);
    expect_codes("R5 mask 0101");
    update('b0010, 1);
    expect_codes("R5 mask 0010");

    // R3 nibbles
    bus_write(3, 0, 0, 'h5, 1);
    bus_write(3, 0, 1, 'hA, 1);
    bus_write(3, 0, 2, 'hF, 1);
    bus_write(3, 0, 3, 'h7, 1);
    bus_read("R3 word", 3, 2, 0, 0);
    bus_read("R3 nibble1", 3, 0, 1, 0);
    bus_read("R3 nibble3 absent", 3, 0, 3, 0);
    update('b1000, 1);
    expect_codes("R3 after update");

    // R4 byte and ignored pieces
    bus_write(1, 1, 0, 'h3C, 1);
    bus_write(1, 1, 1, 'hF9, 1);
    bus_write(1, 1, 2, 'hFF, 1);
    bus_write(1, 1, 3, 'hFF, 1);
    bus_write(1, 2, 1, 'hFFF, 1);
    bus_write(1, 3, 0, 'hFFF, 1);
    bus_read("R4 word", 1, 2, 0, 0);
    bus_read("R4 high part", 1, 1, 1, 0);
    bus_read("R4 low byte", 1, 1, 0, 0);

    // R11 deselected strobes
    bus_write(1, 2, 0, 'h000, 0);
    update('b1111, 0);
    bus_read("R11 write ignored", 1, 2, 0, 0);
    expect_codes("R11 update ignored");

    // R7 quiet bus
    @(negedge clk); rd = 1; cs = 0; #1;
    push("R7 oe cs low", 2, 0, 0); push("R7 data cs low", 1, 0, 0); drain();
    idle();
    @(negedge clk); cs = 1; #1;
    push("R7 oe rd low", 2, 0, 0); push("R7 data rd low", 1, 0, 0); drain();
    idle();

    // R8 modes
    mode_write(2, 3);
    mode_write(3, 2);
    bus_read("R8 mode ch2", 2, 0, 0, 1);
    bus_read("R8 mode ch3", 3, 0, 0, 1);
    for (int c = 0; c < NC; c++) begin
      push("R8 bip", 3, c, m_md[c] & 1);
      push("R8 gain", 4, c, (m_md[c] >> 1) & 1);
    end
    drain();

    // R10 asynchronous zero
    set_zero(1);
    expect_codes("R10 forced");
    bus_write(2, 2, 0, 'h111, 1);
    update('b0100, 1);
    expect_codes("R10 held during update");
    set_zero(0);
    expect_codes("R10 released");

    // R9 transparent
    mode_write(0, 4);
    bus_write(0, 2, 0, 'h777, 1);
    expect_codes("R9 single transparent");
    for (int c = 1; c < NC; c++) mode_write(c, 4 | m_md[c]);
    for (int c = 0; c < NC; c++) bus_write(c, 0, 0, c + 1, 1);
    expect_codes("R9 all transparent");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule